// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses the two ALU operands for the execute stage of a five-stage in-order pipeline. For each operand it compares the source register number carried by the instruction in execute with the destination register numbers and write-enable flags of the two older instructions still in flight. One of them has just left execute and is now in the memory stage. The other is in write-back. It then steers one of three values onto the operand: the register-file read, the memory-stage ALU result, or the write-back value.

The decision logic is purely combinational. A result produced one or two instructions earlier reaches a dependent instruction in the same cycle. Back-to-back dependent ALU instructions therefore run without stalls, at one instruction per cycle. The newest producer takes priority, and register 0, which is hard-wired to zero, is never bypassed. Each operand is decided on its own, so the two operands can draw from different stages in the same cycle.

Top module: `fwd_unit`

## Requirements
- R1: Each select output uses this encoding: 2'b00 is the register-file value, 2'b01 is the write-back value, and 2'b10 is the memory-stage result. The code 2'b11 is never produced.
- R2: Operand A takes the memory-stage result, with select 2'b10, when `exm_we` is 1, `exm_rd` is nonzero and `exm_rd` equals `id_rs`.
- R3: Operand B takes the memory-stage result, with select 2'b10, when `exm_we` is 1, `exm_rd` is nonzero and `exm_rd` equals `id_rt`.
- R4: An operand takes the write-back value, with select 2'b01, when four conditions hold: `mwb_we` is 1, `mwb_rd` is nonzero, `mwb_rd` equals that operand's source register, and the memory-stage path is not selected for that operand.
- R5: When both older stages write the operand's source register, the memory-stage result wins.
- R6: A destination register number of 0 never causes forwarding from either stage, even when its write enable is 1.
- R7: A stage whose write enable is 0 never forwards. A matching memory-stage entry with write enable 0 does not block forwarding from write-back.
- R8: When neither stage forwards to an operand, that operand equals its register-file value with select 2'b00.
- R9: Operands A and B are decided independently. In one cycle, A may take one stage while B takes the other.
- R10: The outputs follow the inputs with no clock latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | Source register number for operand A, instruction in execute |
| id_rt | input | 5 | Source register number for operand B, instruction in execute |
| rf_rs_val | input | 32 | Register-file read value for operand A |
| rf_rt_val | input | 32 | Register-file read value for operand B |
| exm_we | input | 1 | Memory-stage instruction writes a register |
| exm_rd | input | 5 | Memory-stage destination register number |
| exm_result | input | 32 | Memory-stage ALU result |
| mwb_we | input | 1 | Write-back instruction writes a register |
| mwb_rd | input | 5 | Write-back destination register number |
| mwb_value | input | 32 | Value being written back |
| fwd_a_sel | output | 2 | Source select for operand A |
| fwd_b_sel | output | 2 | Source select for operand B |
| opnd_a | output | 32 | Operand A to the ALU |
| opnd_b | output | 32 | Operand B to the ALU |

## Verification
Two functions can apply to the same operand in the same cycle: memory-stage forwarding and write-back forwarding. This happens when both older instructions name the same nonzero destination. The bench provokes this with directed vectors and with random vectors drawn from a register range of only four numbers, so collisions are frequent. Every such case is judged by requiring the memory-stage result, R5. The directed set also pairs a register-0 destination and a matching entry with its write enable cleared against a live write-back match. This shows that only a real producer shadows the older one.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic mem_hit;
        logic wb_hit;
    } hit_t;

endpackage

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              exm_we,
    input  logic [REG_AW-1:0] exm_rd,
    input  logic              mwb_we,
    input  logic [REG_AW-1:0] mwb_rd,
    output fwd_sel_e          sel
);

    hit_t hit_d;

    always_comb begin
        hit_d         = '0;
        hit_d.mem_hit = exm_we && (exm_rd != '0) && (exm_rd == src);
        hit_d.wb_hit  = mwb_we && (mwb_rd != '0) && (mwb_rd == src)
                        && !hit_d.mem_hit;
    end

    always_comb begin
        if (hit_d.mem_hit)
            sel = SEL_MEM;
        else if (hit_d.wb_hit)
            sel = SEL_WB;
        else
            sel = SEL_RF;
    end

    always_comb begin
        // R6
        zero_dst_mem_chk: assert (!(sel == SEL_MEM && exm_rd == '0))
            else $error("memory-stage forward from register 0");
        // R6
        zero_dst_wb_chk: assert (!(sel == SEL_WB && mwb_rd == '0))
            else $error("write-back forward from register 0");
        // R7
        we_gate_chk: assert (!((sel == SEL_MEM && !exm_we) || (sel == SEL_WB && !mwb_we)))
            else $error("forward from a stage that does not write");
    end

endmodule

// File: rtl/opnd_mux.sv
module opnd_mux
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  fwd_sel_e        sel,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] mem_val,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] out
);

    always_comb begin
        unique case (sel)
            SEL_MEM: out = mem_val;
            SEL_WB:  out = wb_val;
            default: out = rf_val;
        endcase
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int XLEN   = 32
) (
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic [XLEN-1:0]   rf_rs_val,
    input  logic [XLEN-1:0]   rf_rt_val,
    input  logic              exm_we,
    input  logic [REG_AW-1:0] exm_rd,
    input  logic [XLEN-1:0]   exm_result,
    input  logic              mwb_we,
    input  logic [REG_AW-1:0] mwb_rd,
    input  logic [XLEN-1:0]   mwb_value,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic [XLEN-1:0]   opnd_a,
    output logic [XLEN-1:0]   opnd_b
);

    localparam int NUM_OPND = 2;

    logic [REG_AW-1:0] src_d [NUM_OPND];
    logic [XLEN-1:0]   rf_d  [NUM_OPND];
    fwd_sel_e          sel_d [NUM_OPND];
    logic [XLEN-1:0]   out_d [NUM_OPND];

    assign src_d[0] = id_rs;
    assign src_d[1] = id_rt;
    assign rf_d[0]  = rf_rs_val;
    assign rf_d[1]  = rf_rt_val;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_select #(.REG_AW(REG_AW)) u_sel (
            .src    (src_d[g]),
            .exm_we (exm_we),
            .exm_rd (exm_rd),
            .mwb_we (mwb_we),
            .mwb_rd (mwb_rd),
            .sel    (sel_d[g])
        );

        opnd_mux #(.XLEN(XLEN)) u_mux (
            .sel     (sel_d[g]),
            .rf_val  (rf_d[g]),
            .mem_val (exm_result),
            .wb_val  (mwb_value),
            .out     (out_d[g])
        );
    end

    assign fwd_a_sel = sel_d[0];
    assign fwd_b_sel = sel_d[1];
    assign opnd_a    = out_d[0];
    assign opnd_b    = out_d[1];

    always_comb begin
        // R1
        sel_legal_chk: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11)
            else $error("illegal select code");
        // R5
        newest_wins_chk: assert (!(exm_we && exm_rd != '0 && exm_rd == id_rs)
                                 || fwd_a_sel == 2'b10)
            else $error("operand A did not take memory-stage producer");
        // R8
        rf_path_chk: assert (fwd_a_sel != 2'b00 || opnd_a == rf_rs_val)
            else $error("operand A not register-file value on select 00");
        // R4
        wb_path_chk: assert (fwd_b_sel != 2'b01 || opnd_b == mwb_value)
            else $error("operand B not write-back value on select 01");
    end

endmodule

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  id_rs = '0, id_rt = '0, exm_rd = '0, mwb_rd = '0;
    logic [31:0] rf_rs_val = '0, rf_rt_val = '0, exm_result = '0, mwb_value = '0;
    logic        exm_we = 1'b0, mwb_we = 1'b0;
    logic [1:0]  fwd_a_sel, fwd_b_sel;
    logic [31:0] opnd_a, opnd_b;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    fwd_unit u0 (
        .id_rs(id_rs), .id_rt(id_rt), .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val),
        .exm_we(exm_we), .exm_rd(exm_rd), .exm_result(exm_result),
        .mwb_we(mwb_we), .mwb_rd(mwb_rd), .mwb_value(mwb_value),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: returns select code (integer) and requirement tag.
    function automatic int ref_sel(input int src, input bit is_b, output string tag);
        bit newest = exm_we && (int'(exm_rd) != 0) && (int'(exm_rd) == src);
        bit older  = mwb_we && (int'(mwb_rd) != 0) && (int'(mwb_rd) == src);
        if (newest) begin
            tag = older ? "R5" : (is_b ? "R3" : "R2");
            return 2;
        end
        if (older) begin
            tag = (exm_rd == mwb_rd) ? "R7" : "R4";
            return 1;
        end
        if ((exm_we && int'(exm_rd) == src) || (mwb_we && int'(mwb_rd) == src))
            tag = "R6";
        else if (int'(exm_rd) == src || int'(mwb_rd) == src)
            tag = "R7";
        else
            tag = "R8";
        return 0;
    endfunction

    function automatic logic [31:0] pick(input int s, input logic [31:0] rf);
        if (s == 2) return exm_result;
        if (s == 1) return mwb_value;
        return rf;
    endfunction

    task automatic compare(input string note);
        string ta, tb;
        int sa, sb;
        sa = ref_sel(int'(id_rs), 1'b0, ta);
        sb = ref_sel(int'(id_rt), 1'b1, tb);
        check({ta, " ", note}, "sel A", {30'd0, fwd_a_sel}, sa);
        check({tb, " ", note}, "sel B", {30'd0, fwd_b_sel}, sb);
        check({ta, " ", note}, "opnd A", opnd_a, pick(sa, rf_rs_val));
        check({tb, " ", note}, "opnd B", opnd_b, pick(sb, rf_rt_val));
        // R1: 2'b11 never appears
        check("R1", "sel code legal", {31'd0, (fwd_a_sel == 2'b11) || (fwd_b_sel == 2'b11)}, 0);
    endtask

    // Apply a vector after the falling edge; R10: same-cycle result, sample 1 ns later.
    task automatic apply(input int rs, input int rt, input bit ew, input int erd,
                         input bit ww, input int wrd, input string note);
        @(negedge clk);
        id_rs = 5'(rs); id_rt = 5'(rt);
        exm_we = ew; exm_rd = 5'(erd);
        mwb_we = ww; mwb_rd = 5'(wrd);
        rf_rs_val  = 32'hA000_0000 | 32'(rs);
        rf_rt_val  = 32'hB000_0000 | 32'(rt);
        exm_result = $urandom;
        mwb_value  = $urandom;
        #1;
        compare(note);
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Initial state: all-zero inputs give register-file selects (R8)
        check("R8", "reset sel A", {30'd0, fwd_a_sel}, 0);
        check("R8", "reset sel B", {30'd0, fwd_b_sel}, 0);

        apply(3, 4, 1, 9, 1, 10, "no hazard");
        apply(3, 4, 1, 3, 0, 0, "memory-stage to A");
        apply(3, 4, 1, 4, 1, 7, "memory-stage to B");
        apply(5, 6, 1, 9, 1, 5, "write-back to A");
        apply(5, 6, 0, 0, 1, 6, "write-back to B");
        apply(8, 8, 1, 8, 1, 8, "double match newest wins");
        apply(0, 0, 1, 0, 1, 0, "register 0 never forwarded");
        apply(0, 2, 1, 0, 1, 2, "r0 in mem, wb to B");
        apply(7, 7, 0, 7, 0, 7, "write enables off");
        apply(7, 7, 0, 7, 1, 7, "disabled mem does not shadow wb");
        apply(11, 12, 1, 11, 1, 12, "R9 A mem and B wb same cycle");
        apply(12, 11, 1, 11, 1, 12, "R9 swapped");
        apply(31, 31, 1, 31, 1, 31, "highest register");

        for (int i = 0; i < 400; i++) begin
            apply($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom),
                  $urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), "random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule